// File: doc/BRIEF.md
# Two-Tape Sequential Input Reader

This block serves a single "read next input word" operation for a small processor core. Two sequential tapes feed it. Tape 0 carries the primary input and tape 1 carries the auxiliary input. Each tape is a word stream with a valid/ready handshake and a level that reports the end of the tape. A read strobe names a tape by index. One cycle later the block presents a registered result word and a failure flag, and it holds both until the next read.

A read succeeds when the named tape is neither marked exhausted nor at its end and has a word on offer. The block then consumes that word with a one-cycle ready pulse, returns it and clears the flag. Every other case returns the all-zero word with the flag set:

- an index other than 0 or 1,
- a tape that has run out,
- a tape whose source has no word ready yet.

Running into the end of a tape marks that tape exhausted for good, until reset. Each tape keeps its own exhaustion mark and its own count of consumed words, and the count is visible on a port.

Top module: `tape_reader`

## Requirements
- R1: With `rd_req` high and `rd_sel` = 0, a read of the primary tape that succeeds returns the next word of tape 0 in stream order. With `rd_sel` = 1, it returns the next word of tape 1. In both cases the flag is 0.
- R2: A read with `rd_sel` not equal to 0 or 1 returns 0 with the flag at 1, and consumes no word from either tape.
- R3: A read of a tape whose end indication is high returns 0 with the flag at 1, and marks that tape exhausted.
- R4: Once a tape is exhausted, every later read of it returns 0 with flag 1, even after its end indication falls and words are offered again. Only reset clears the mark.
- R5: Exhausting one tape has no effect on reads of the other tape.
- R6: A tape's ready output pulses for exactly the cycle of a read of that tape that succeeds, and is low otherwise. Its position count rises by one on each such read and on nothing else.
- R7: `rd_done` is high for exactly the one cycle after a strobe. `rd_result` and `rd_flag` take their new values in that same cycle and hold them while no read is requested.
- R8: A read of a tape that is not at its end but has its valid low returns 0 with flag 1. It does not consume a word and does not mark the tape exhausted.
- R9: A synchronous active-low reset clears both position counts, both exhaustion marks, the result, the flag and `rd_done`.
- R10: Whenever `rd_flag` is 1, `rd_result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Read strobe, one cycle per read |
| rd_sel | input | SEL_W | Tape index of the read |
| pri_data | input | W | Primary tape word on offer |
| pri_valid | input | 1 | Primary tape word is valid |
| pri_end | input | 1 | Primary tape has no words left |
| pri_ready | output | 1 | Primary tape word consumed this cycle |
| aux_data | input | W | Auxiliary tape word on offer |
| aux_valid | input | 1 | Auxiliary tape word is valid |
| aux_end | input | 1 | Auxiliary tape has no words left |
| aux_ready | output | 1 | Auxiliary tape word consumed this cycle |
| rd_done | output | 1 | Result of a read is presented this cycle |
| rd_result | output | W | Word returned by the last read |
| rd_flag | output | 1 | Last read failed |
| pri_pos | output | POS_W | Words consumed from the primary tape |
| aux_pos | output | POS_W | Words consumed from the auxiliary tape |

## Verification
The bench drives the full range of index values, including index 2 and the all-ones index. A decoder that compares only the low bit would return a tape word for these and move a position count. It reads a tape past its end, then lowers the end indication and offers words again. A design whose exhaustion mark is not sticky would then return data. It also exhausts one tape while still reading the other, which catches an exhaustion mark shared between the two tapes. A stalled source with valid low and end low must fail without consuming a word or latching exhaustion, so a design that treats a stall as the end of the tape would get every later read of that tape wrong. Idle cycles after a read confirm that the result holds, and a reset in the middle of the run confirms that the exhaustion marks and counts clear.

// File: rtl/tr_pkg.sv
// Package: shared constants for the two-tape reader.
// Assumes exactly two tapes; index values are part of the behaviour.
package tr_pkg;
    localparam int TAPE_COUNT = 2;
    typedef enum int {
        TAPE_PRIMARY = 0,
        TAPE_AUX     = 1
    } tape_id_e;
endpackage

// File: rtl/tr_tape_port.sv
// Module: tr_tape_port
// One tape's read-side state: sticky exhaustion mark, position count and
// the ready pulse that consumes a word. Assumes sel_hit is high only in
// the strobe cycle of a read naming this tape.
module tr_tape_port #(
    parameter int W     = 16,
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_hit,
    input  logic             src_valid,
    input  logic             src_end,
    output logic             take,
    output logic             exhausted,
    output logic [POS_W-1:0] pos
);
    logic             exh_q;
    logic [POS_W-1:0] pos_q;

    // Consume a word only for a live, non-ended tape that offers one.
    always_comb begin
        take = sel_hit && !exh_q && !src_end && src_valid;
    end

    // Latch exhaustion when a read meets the end of the tape.
    always_ff @(posedge clk) begin
        if (!rst_n)
            exh_q <= 1'b0;
        else if (sel_hit && src_end)
            exh_q <= 1'b1;
    end

    // Count consumed words.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= '0;
        else if (take)
            pos_q <= pos_q + 1'b1;
    end

    assign exhausted = exh_q;
    assign pos       = pos_q;

    // R4
    exh_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exh_q |=> exh_q);
    // R6
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(pos_q));
    // R6
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (pos_q == $past(pos_q) + 1'b1));
    // R4
    no_take_exh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exh_q |-> !take);
endmodule

// File: rtl/tr_result_stage.sv
// Module: tr_result_stage
// Registers the outcome of a read: the consumed word on success, zero and
// a raised flag on any failure. Assumes at most one bit of take_vec is set.
module tr_result_stage #(
    parameter int W = 16,
    parameter int N = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [N-1:0]        take_vec,
    input  logic [N-1:0][W-1:0] data_vec,
    output logic                done,
    output logic [W-1:0]        result,
    output logic                flag
);
    logic [W-1:0] pick;
    logic         any_take;

    // Select the word of whichever tape was consumed.
    always_comb begin
        pick     = '0;
        any_take = |take_vec;
        for (int i = 0; i < N; i++) begin
            if (take_vec[i])
                pick = data_vec[i];
        end
    end

    // Capture result and flag on a strobe, hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            flag   <= 1'b0;
        end else if (req) begin
            result <= any_take ? pick : '0;
            flag   <= !any_take;
        end
    end

    // Completion pulse one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else
            done <= req;
    end

    // R10
    flag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> (result == '0));
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> ($stable(result) && $stable(flag)));
    // R7
    done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> done);
    // R6
    one_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_vec));
endmodule

// File: rtl/tape_reader.sv
// Module: tape_reader (top)
// Two-tape sequential input reader. Index 0 is the primary tape and
// index 1 the auxiliary tape; any other index fails. Assumes tape sources
// hold data/valid/end stable until ready is seen.
module tape_reader #(
    parameter int W     = 16,
    parameter int SEL_W = 4,
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic [SEL_W-1:0] rd_sel,
    input  logic [W-1:0]     pri_data,
    input  logic             pri_valid,
    input  logic             pri_end,
    output logic             pri_ready,
    input  logic [W-1:0]     aux_data,
    input  logic             aux_valid,
    input  logic             aux_end,
    output logic             aux_ready,
    output logic             rd_done,
    output logic [W-1:0]     rd_result,
    output logic             rd_flag,
    output logic [POS_W-1:0] pri_pos,
    output logic [POS_W-1:0] aux_pos
);
    import tr_pkg::*;
    localparam int N = TAPE_COUNT;

    logic [N-1:0][W-1:0]     data_vec;
    logic [N-1:0]            valid_vec;
    logic [N-1:0]            end_vec;
    logic [N-1:0]            take_vec;
    logic [N-1:0]            exh_vec;
    logic [N-1:0]            hit_vec;
    logic [N-1:0][POS_W-1:0] pos_vec;

    // Gather the per-tape stream signals into indexed vectors.
    always_comb begin
        data_vec[TAPE_PRIMARY]  = pri_data;
        data_vec[TAPE_AUX]      = aux_data;
        valid_vec[TAPE_PRIMARY] = pri_valid;
        valid_vec[TAPE_AUX]     = aux_valid;
        end_vec[TAPE_PRIMARY]   = pri_end;
        end_vec[TAPE_AUX]       = aux_end;
    end

    for (genvar g = 0; g < N; g++) begin : g_tape
        // Full-width index decode for this tape.
        assign hit_vec[g] = rd_req && (rd_sel == SEL_W'(g));

        tr_tape_port #(.W(W), .POS_W(POS_W)) port_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel_hit   (hit_vec[g]),
            .src_valid (valid_vec[g]),
            .src_end   (end_vec[g]),
            .take      (take_vec[g]),
            .exhausted (exh_vec[g]),
            .pos       (pos_vec[g])
        );
    end

    tr_result_stage #(.W(W), .N(N)) res_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (rd_req),
        .take_vec (take_vec),
        .data_vec (data_vec),
        .done     (rd_done),
        .result   (rd_result),
        .flag     (rd_flag)
    );

    assign pri_ready = take_vec[TAPE_PRIMARY];
    assign aux_ready = take_vec[TAPE_AUX];
    assign pri_pos   = pos_vec[TAPE_PRIMARY];
    assign aux_pos   = pos_vec[TAPE_AUX];

    // R2
    bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_sel > SEL_W'(1)) |-> (take_vec == '0));
    // R5
    exh_indep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_vec[TAPE_AUX]) |=> (exh_vec[TAPE_AUX] == $past(exh_vec[TAPE_AUX])));
endmodule

// File: tb/tape_reader_tb_top.sv
module tape_reader_tb_top;
    localparam int W     = 16;
    localparam int SEL_W = 4;
    localparam int POS_W = 16;

    typedef struct packed {
        logic [W-1:0]     res;
        logic             flg;
        logic [POS_W-1:0] p0;
        logic [POS_W-1:0] p1;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_req = 1'b0;
    logic [SEL_W-1:0] rd_sel = '0;
    logic [W-1:0] pri_data, aux_data;
    logic pri_valid, aux_valid, pri_end, aux_end, pri_ready, aux_ready;
    logic rd_done, rd_flag;
    logic [W-1:0] rd_result;
    logic [POS_W-1:0] pri_pos, aux_pos;

    always #10 clk = ~clk;

    tape_reader #(.W(W), .SEL_W(SEL_W), .POS_W(POS_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_sel(rd_sel),
        .pri_data(pri_data), .pri_valid(pri_valid), .pri_end(pri_end), .pri_ready(pri_ready),
        .aux_data(aux_data), .aux_valid(aux_valid), .aux_end(aux_end), .aux_ready(aux_ready),
        .rd_done(rd_done), .rd_result(rd_result), .rd_flag(rd_flag),
        .pri_pos(pri_pos), .aux_pos(aux_pos)
    );

    // Tape source models
    int src_idx [2];
    int src_len [2];
    logic src_stall [2];

    function automatic logic [W-1:0] word_of(int t, int i);
        return (t == 0) ? W'(16'hA000 + i * 3) : W'(16'h5000 ^ (i * 17));
    endfunction

    always_comb begin
        pri_data  = word_of(0, src_idx[0]);
        aux_data  = word_of(1, src_idx[1]);
        pri_end   = src_idx[0] >= src_len[0];
        aux_end   = src_idx[1] >= src_len[1];
        pri_valid = !pri_end && !src_stall[0];
        aux_valid = !aux_end && !src_stall[1];
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            src_idx[0] <= 0;
            src_idx[1] <= 0;
        end else begin
            if (pri_ready) src_idx[0] <= src_idx[0] + 1;
            if (aux_ready) src_idx[1] <= src_idx[1] + 1;
        end
    end

    // Scoreboard
    exp_t  exp_q[$];
    string tag_q[$];
    int total = 0;
    int bad = 0;
    int epos [2];
    logic eexh [2];
    exp_t last_exp;
    bit finished = 0;

    task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic do_read(input logic [SEL_W-1:0] sel, input string tag);
        exp_t e;
        int t;
        @(negedge clk);
        e = '0;
        if (sel < 2) begin
            t = int'(sel);
            if (src_idx[t] >= src_len[t]) eexh[t] = 1'b1;
            if (!eexh[t] && !src_stall[t] && src_idx[t] < src_len[t]) begin
                e.res = word_of(t, epos[t]);
                e.flg = 1'b0;
                epos[t]++;
            end else begin
                e.flg = 1'b1;
            end
        end else begin
            e.flg = 1'b1;
        end
        e.p0 = POS_W'(epos[0]);
        e.p1 = POS_W'(epos[1]);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        last_exp = e;
        rd_sel = sel;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n && rd_done) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected done", 64'(rd_done), 64'd0);
            end else begin
                exp_t e;
                string tg;
                e = exp_q.pop_front();
                tg = tag_q.pop_front();
                check({tg, " result"}, 64'(rd_result), 64'(e.res));
                check({tg, " flag"}, 64'(rd_flag), 64'(e.flg));
                check({tg, " pri_pos"}, 64'(pri_pos), 64'(e.p0));
                check({tg, " aux_pos"}, 64'(aux_pos), 64'(e.p1));
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        epos[0] = 0; epos[1] = 0;
        eexh[0] = 1'b0; eexh[1] = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        src_len[0] = 4; src_len[1] = 3;
        src_stall[0] = 1'b0; src_stall[1] = 1'b0;
        do_reset();
        @(negedge clk);
        // R9 reset state
        check("R9 done", 64'(rd_done), 64'd0);
        check("R9 result", 64'(rd_result), 64'd0);
        check("R9 flag", 64'(rd_flag), 64'd0);
        check("R9 pos", 64'({pri_pos, aux_pos}), 64'd0);
        // R1 ordered reads of both tapes
        do_read(0, "R1 pri0");
        do_read(0, "R1 pri1");
        do_read(1, "R1 aux0");
        // R2 unsupported indexes
        do_read(2, "R2 idx2");
        do_read(4'hF, "R2 idx15");
        // R7 hold while idle, R6 no ready while idle
        repeat (3) @(negedge clk);
        check("R7 hold result", 64'(rd_result), 64'(last_exp.res));
        check("R7 hold flag", 64'(rd_flag), 64'(last_exp.flg));
        check("R6 idle ready", 64'({pri_ready, aux_ready}), 64'd0);
        // R8 stalled source
        src_stall[1] = 1'b1;
        do_read(1, "R8 aux stall");
        src_stall[1] = 1'b0;
        do_read(1, "R8 aux after stall");
        // R3 exhaust primary
        do_read(0, "R1 pri2");
        do_read(0, "R1 pri3");
        do_read(0, "R3 pri end");
        // R5 aux unaffected
        do_read(1, "R5 aux2");
        // R4 sticky: tape refilled, still exhausted
        src_len[0] = 6;
        do_read(0, "R4 pri refilled");
        do_read(0, "R4 pri again");
        do_read(1, "R3 aux end");
        do_read(1, "R4 aux after end");
        // R9 reset clears exhaustion
        do_reset();
        @(negedge clk);
        check("R9 pos after reset", 64'({pri_pos, aux_pos}), 64'd0);
        do_read(0, "R9 pri after reset");
        do_read(1, "R9 aux after reset");
        repeat (3) @(negedge clk);
        check("R7 queue drained", 64'(exp_q.size()), 64'd0);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end
endmodule